// File: doc/BRIEF.md
# DDR Serial-to-Parallel Input Deserializer

This block turns one serial input into a parallel word. A fast bit clock samples the serial line on both of its edges. The sampled bits go through a short transfer stage into a shift register. On every rising edge of a slower, phase-aligned word clock, the shift register is copied to the output. The word clock runs at the bit clock divided by WIDTH/2. The serial line is taken from one of three inputs: a direct pin input, a delayed input, or a loopback from a companion serializer. The choice is fixed at elaboration.

In memory mode the bit clock is a strobe. The transfer stage and the shift register then run on a free-running clock of the same frequency, so captured data leaves the strobe domain there. In networking mode that clock input is ignored, and the transfer stage runs on the bit clock itself.

Reset is active low and clears the block asynchronously. It must be released in step with the word clock. Inside the block, the release is carried to the bit-clock logic on the next rising bit-clock edge. The four front flops take reset values set by a parameter. A valid flag marks the output as unusable for two word-clock cycles after release. Several lanes that share one reset therefore come out of it word-aligned.

Top module: `ddr_deser`

## Requirements
- R1: SRC_SEL picks the serial input: 0 takes din_pin_i, 1 takes din_dly_i, 2 takes din_fb_i. The two inputs that are not picked have no effect on q_o.
- R2: In networking mode (MEM_MODE=0), every rising and falling bit_clk_i edge samples one bit. Count those edges over both polarities. The word loaded at a rising div_clk_i edge with index E then holds the bits sampled at edges E-5-(WIDTH-1) through E-5. The oldest bit is on q_o[WIDTH-1].
- R3: In memory mode (MEM_MODE=1), the transfer stage and the shift register run on rising oclk_i. With oclk_i rising three quarters of a bit period after bit_clk_i, the word loaded at div_clk_i edge E holds the bits from edges E-3-(WIDTH-1) through E-3, oldest on the MSB.
- R4: In networking mode, oclk_i has no effect on q_o or valid_o.
- R5: rst_ni low drives q_o and valid_o to zero at once, without any clock edge.
- R6: The bit-clock logic leaves reset on the first rising bit_clk_i edge after rst_ni rises. Until then the front flops hold their INIT bits: INIT[0] for the rising-edge capture flop, INIT[1] for the falling-edge capture flop, INIT[2] for the rising transfer flop and INIT[3] for the falling transfer flop. Take the div_clk_i edge that precedes the release as edge index e0. The word loaded four bit periods after that edge has {INIT[2], INIT[3], INIT[0], bit of edge e0+3} in bits 3..0 and zeros above.
- R7: valid_o is low during reset and after the first div_clk_i edge following release. It is high from the second such edge on, until the next reset.
- R8: Each reset pulse spans at least two rising div_clk_i edges, and rst_ni rises just after a rising div_clk_i edge.
- R9: Lanes that share rst_ni raise valid_o on the same div_clk_i edge and load words aligned to the same bit-edge positions.
- R10: With WIDTH=4 and div_clk_i at half the bit_clk_i rate, R2 and R7 hold unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk_i | input | 1 | Bit clock; the serial line is sampled on both edges |
| div_clk_i | input | 1 | Word clock, bit_clk_i divided by WIDTH/2, phase-aligned |
| oclk_i | input | 1 | Free-running transfer clock used in memory mode |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, release in step with div_clk_i |
| din_pin_i | input | 1 | Direct serial input (SRC_SEL=0) |
| din_dly_i | input | 1 | Delayed serial input (SRC_SEL=1) |
| din_fb_i | input | 1 | Loopback serial input from a serializer (SRC_SEL=2) |
| q_o | output | WIDTH | Parallel word, oldest bit on the MSB |
| valid_o | output | 1 | High once the word is usable after reset |

## Verification
The bench builds four lanes from one reset:
- Two 8-bit networking lanes read the pin and delayed inputs and share the same INIT value. This brings the source select, lane lockstep and the INIT bits in the first word within reach.
- An 8-bit memory-mode lane reads the loopback input, with oclk_i lagging by three quarters of a bit period. This separates its latency from that of the networking lanes.
- A 4-bit networking lane runs on a half-rate word clock.

Both 8-bit networking lanes also see that offset oclk_i or a constant on it, so any use of the transfer clock in networking mode would shift their words.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned SRC_PIN = 0;
  localparam int unsigned SRC_DLY = 1;
  localparam int unsigned SRC_FB  = 2;
  localparam int unsigned FRONT_FLOPS = 4;
endpackage

// File: rtl/dsr_rst_sync.sv
module dsr_rst_sync (
  input  logic bit_clk_i,
  input  logic rst_ni,
  output logic rst_bit_no
);
  // release carried to the first rising bit clock edge
  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_bit_no <= 1'b0;
    else         rst_bit_no <= 1'b1;
  end

  p_bit_release_r6: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |=> rst_bit_no);
endmodule

// File: rtl/dsr_capture.sv
module dsr_capture import dsr_pkg::*; #(
  parameter int unsigned WIDTH = 8,
  parameter logic [FRONT_FLOPS-1:0] INIT = '0
) (
  input  logic             bit_clk_i,
  input  logic             xfer_clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  output logic [WIDTH-1:0] word_o
);
  logic cap_p, cap_n, stg_p, stg_n;
  logic [WIDTH-1:0] shreg;

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_p <= INIT[0];
    else         cap_p <= din_i;
  end

  always_ff @(negedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_n <= INIT[1];
    else         cap_n <= din_i;
  end

  // pair moves together; rising sample is the older bit
  always_ff @(posedge xfer_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_p <= INIT[2];
      stg_n <= INIT[3];
      shreg <= '0;
    end else begin
      stg_p <= cap_p;
      stg_n <= cap_n;
      shreg <= {shreg[WIDTH-3:0], stg_p, stg_n};
    end
  end

  assign word_o = shreg;
endmodule

// File: rtl/dsr_out.sv
module dsr_out #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned HOLD  = 2
) (
  input  logic             div_clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] q_o,
  output logic             valid_o
);
  logic [HOLD-1:0] vld_sh;

  always_ff @(posedge div_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o    <= '0;
      vld_sh <= '0;
    end else begin
      q_o    <= word_i;
      vld_sh <= {vld_sh[HOLD-2:0], 1'b1};
    end
  end

  assign valid_o = vld_sh[HOLD-1];

  p_valid_wait_r7: assert property (@(posedge div_clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |=> !valid_o);
  p_valid_up_r7: assert property (@(posedge div_clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |=> ##1 valid_o);
  p_valid_hold_r7: assert property (@(posedge div_clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/ddr_deser.sv
module ddr_deser import dsr_pkg::*; #(
  parameter int unsigned WIDTH    = 8,
  parameter bit          MEM_MODE = 1'b0,
  parameter int unsigned SRC_SEL  = SRC_PIN,
  parameter logic [FRONT_FLOPS-1:0] INIT = '0
) (
  input  logic             bit_clk_i,
  input  logic             div_clk_i,
  input  logic             oclk_i,
  input  logic             rst_ni,
  input  logic             din_pin_i,
  input  logic             din_dly_i,
  input  logic             din_fb_i,
  output logic [WIDTH-1:0] q_o,
  output logic             valid_o
);
  localparam int unsigned VALID_HOLD = 2;

  logic             din;
  logic             xfer_clk;
  logic             rst_bit_n;
  logic [WIDTH-1:0] word;

  generate
    if (SRC_SEL == SRC_DLY) begin : g_src_dly
      logic unused_src;
      assign din        = din_dly_i;
      assign unused_src = din_pin_i ^ din_fb_i;
    end else if (SRC_SEL == SRC_FB) begin : g_src_fb
      logic unused_src;
      assign din        = din_fb_i;
      assign unused_src = din_pin_i ^ din_dly_i;
    end else begin : g_src_pin
      logic unused_src;
      assign din        = din_pin_i;
      assign unused_src = din_dly_i ^ din_fb_i;
    end

    if (MEM_MODE) begin : g_mem
      assign xfer_clk = oclk_i;
    end else begin : g_net
      logic unused_oclk;
      assign xfer_clk    = bit_clk_i;
      assign unused_oclk = oclk_i;
    end
  endgenerate

  dsr_rst_sync u_rst (
    .bit_clk_i (bit_clk_i),
    .rst_ni    (rst_ni),
    .rst_bit_no(rst_bit_n)
  );

  dsr_capture #(.WIDTH(WIDTH), .INIT(INIT)) u_cap (
    .bit_clk_i (bit_clk_i),
    .xfer_clk_i(xfer_clk),
    .rst_ni    (rst_bit_n),
    .din_i     (din),
    .word_o    (word)
  );

  dsr_out #(.WIDTH(WIDTH), .HOLD(VALID_HOLD)) u_out (
    .div_clk_i(div_clk_i),
    .rst_ni   (rst_ni),
    .word_i   (word),
    .q_o      (q_o),
    .valid_o  (valid_o)
  );

  generate
    if (WIDTH > FRONT_FLOPS) begin : g_chk_first
      // first word after release carries only front-flop bits
      p_first_word_r6: assert property (@(posedge div_clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |=> (q_o[WIDTH-1:FRONT_FLOPS] == '0));
    end
  endgenerate
endmodule

// File: tb/sim_ddr_deser.sv
module sim_ddr_deser;
  localparam logic [3:0] INIT_A = 4'b0101;

  logic clk = 1'b0, oclk = 1'b0, div8 = 1'b0, div4 = 1'b0;
  logic rst_n = 1'b0;
  logic din_pin = 1'b0, din_dly = 1'b0, din_fb = 1'b0;
  logic [7:0] q0, q1, q2;
  logic [3:0] q3;
  logic v0, v1, v2, v3;

  int ecnt = 0;
  int pat = 0;
  int rst_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit hist [3][256];
  logic [15:0] lf [3];

  ddr_deser #(.WIDTH(8), .MEM_MODE(1'b0), .SRC_SEL(0), .INIT(INIT_A)) u0 (
    .bit_clk_i(clk), .div_clk_i(div8), .oclk_i(oclk), .rst_ni(rst_n),
    .din_pin_i(din_pin), .din_dly_i(din_dly), .din_fb_i(din_fb),
    .q_o(q0), .valid_o(v0));
  ddr_deser #(.WIDTH(8), .MEM_MODE(1'b0), .SRC_SEL(1), .INIT(INIT_A)) u1 (
    .bit_clk_i(clk), .div_clk_i(div8), .oclk_i(1'b0), .rst_ni(rst_n),
    .din_pin_i(din_pin), .din_dly_i(din_dly), .din_fb_i(din_fb),
    .q_o(q1), .valid_o(v1));
  ddr_deser #(.WIDTH(8), .MEM_MODE(1'b1), .SRC_SEL(2), .INIT(4'b0000)) u2 (
    .bit_clk_i(clk), .div_clk_i(div8), .oclk_i(oclk), .rst_ni(rst_n),
    .din_pin_i(din_pin), .din_dly_i(din_dly), .din_fb_i(din_fb),
    .q_o(q2), .valid_o(v2));
  ddr_deser #(.WIDTH(4), .MEM_MODE(1'b0), .SRC_SEL(0), .INIT(4'b0000)) u3 (
    .bit_clk_i(clk), .div_clk_i(div4), .oclk_i(oclk), .rst_ni(rst_n),
    .din_pin_i(din_pin), .din_dly_i(din_dly), .din_fb_i(din_fb),
    .q_o(q3), .valid_o(v3));

  // one process makes all clocks (2 ns steps, 8 ns bit period) and the data
  initial begin
    int ph;
    lf[0] = 16'hACE1; lf[1] = 16'h1D35; lf[2] = 16'h7B42;
    ph = 0;
    forever begin
      if (ph % 2 == 0) begin
        ecnt = ph / 2;
      end else begin
        int e;
        e = (ph + 1) / 2;
        for (int s = 0; s < 3; s++) begin
          bit b;
          case (pat)
            0:       b = lf[s][0];
            1:       b = ((e + s) % 2) == 1;
            2:       b = 1'b1;
            default: b = 1'b0;
          endcase
          lf[s] = {lf[s][14:0], lf[s][15] ^ lf[s][13] ^ lf[s][12] ^ lf[s][10]};
          hist[s][e % 256] = b;
        end
        din_pin = hist[0][e % 256];
        din_dly = hist[1][e % 256];
        din_fb  = hist[2][e % 256];
      end
      clk  = (ph % 4) < 2;
      oclk = ((ph % 4) == 3) || ((ph % 4) == 0);
      div8 = (ph % 16) < 8;
      div4 = (ph % 8) < 4;
      #2;
      ph++;
    end
  end

  always @(posedge div8) rst_cnt <= rst_n ? 0 : rst_cnt + 1;

  function automatic logic [7:0] exp_word(int s, int e, int lag, int w);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < w; i++) r[w-1-i] = hist[s][(e - lag - (w - 1) + i) % 256];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_release(output int e0);
    @(posedge div8);
    e0 = ecnt;
    #1;
    chk("R8 reset width", 8'(rst_cnt >= 2), 8'd1);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    repeat (3) @(posedge div8);
    #3;
    chk("R5 q0 in reset", q0, 8'h00);
    chk("R5 q2 in reset", q2, 8'h00);
    chk("R7 valid in reset", {4'b0, v0, v1, v2, v3}, 8'h00);
  endtask

  task automatic t_release;
    int e0;
    do_release(e0);
    @(posedge div4); #3;
    chk("R10 u3 valid after 1st edge", {7'b0, v3}, 8'h00);
    @(posedge div8); #3;
    chk("R6 u0 first word INIT", q0, {4'b0000, INIT_A[2], INIT_A[3], INIT_A[0], hist[0][(e0 + 3) % 256]});
    chk("R9 u1 first word INIT", q1, {4'b0000, INIT_A[2], INIT_A[3], INIT_A[0], hist[1][(e0 + 3) % 256]});
    chk("R7 R9 valid low after 1st edge", {6'b0, v0, v1}, 8'h00);
    chk("R10 u3 valid after 2nd edge", {7'b0, v3}, 8'h01);
    @(posedge div8); #3;
    chk("R7 R9 valid high after 2nd edge", {5'b0, v0, v1, v2}, 8'h07);
  endtask

  task automatic t_stream(input int mode, input int n);
    pat = mode;
    repeat (n) begin
      int e;
      @(posedge div4);
      e = ecnt;
      #3;
      chk("R10 u3 word", {4'b0, q3}, exp_word(0, e, 5, 4));
      if (e % 8 == 0) begin
        chk("R2 R4 u0 word", q0, exp_word(0, e, 5, 8));
        chk("R1 u1 delayed source", q1, exp_word(1, e, 5, 8));
        chk("R3 u2 memory mode", q2, exp_word(2, e, 3, 8));
        chk("R9 lockstep valid", {6'b0, v0, v1}, 8'h03);
      end
    end
  endtask

  task automatic t_async_reset;
    int e0;
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R5 async clear q0", q0, 8'h00);
    chk("R5 async clear q2", q2, 8'h00);
    chk("R5 async clear valid", {4'b0, v0, v1, v2, v3}, 8'h00);
    repeat (2) @(posedge div8);
    do_release(e0);
    repeat (2) @(posedge div8);
    #3;
    chk("R7 valid back after reset", {4'b0, v0, v1, v2, v3}, 8'h0F);
  endtask

  task automatic finish_sim;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_release();
    t_stream(0, 40);
    t_stream(1, 24);
    t_stream(2, 16);
    t_stream(3, 16);
    t_async_reset();
    t_stream(0, 40);
    finish_sim();
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_sim();
  end
endmodule